// File: doc/BRIEF.md
# Key-Protected System Control Register File

This block holds a bank of 32-bit system control words behind a single-request, word-indexed read/write port. Index 0 is a protection key. Software writes a fixed unlock value there to open a window of guarded registers. While the key holds any other value, a write into the guarded window is discarded, and the block raises a one-cycle violation pulse instead.

The key is loaded at reset from a configuration input. A board therefore decides whether the bank starts locked (key 0) or already open (key equal to the unlock value). The silicon revision word and two hardware strap words are also taken from inputs at reset. The device-ID word and all other words reset to constants set by parameters. The decode window spans 1024 word indices (a 4 KiB byte window), of which the lower `NUM_REGS` are implemented.

Top module: `sysctl_keyreg`

## Requirements
- R1: After reset, index 0 holds `cfg_reset_key`, index 103 (byte 0x19C) holds `cfg_silicon_rev`, index 28 holds `cfg_strap_a`, index 52 holds `cfg_strap_b`, index 105 (byte 0x1A4) holds `DEV_ID_RST` (default 32'h0000_0A57), every other word is 0, and `rsp_valid` and `lock_violation` are low.
- R2: The bank is unlocked exactly when index 0 holds 32'h1688A8A8. While unlocked, a write to a guarded index (1 to 95, that is, above the key and below `SEG_IDX` = 96, byte 0x180) updates that word.
- R3: While locked, a write to a guarded index leaves every word unchanged.
- R4: `lock_violation` is high for exactly the one cycle after each write that R3 discards, and low after every other request or idle cycle.
- R5: A write to index 0 always stores its data, whatever the lock state. Storing any value other than 32'h1688A8A8 locks the bank.
- R6: Implemented indices from 96 to `NUM_REGS`-1 (default 127), other than 103, accept writes while locked, with no violation.
- R7: Index 103 (the revision word) is read-only. Writes to it are ignored and raise no violation.
- R8: A read request returns `rsp_valid` high with the word's current contents on `rsp_rdata` in the following cycle, independent of the lock state. `rsp_valid` is low after cycles with no read.
- R9: Indices at or above `NUM_REGS` (128) read as 0. Writes to them change no word and raise no violation.
- R10: With `cfg_reset_key` = 32'h1688A8A8 at reset, the bank is unlocked from the first request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_silicon_rev | input | 32 | Revision word loaded at reset |
| cfg_strap_a | input | 32 | First strap word loaded at reset |
| cfg_strap_b | input | 32 | Second strap word loaded at reset |
| cfg_reset_key | input | 32 | Key value loaded at reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 10 | Word index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| lock_violation | output | 1 | One-cycle pulse after a discarded guarded write |

## Verification
The write path is exercised under three key states: reset key 0, the exact unlock value, and a value one bit away from it. These separate an exact compare from a partial one, and show that a relock takes effect on the very next write. Writes land on indices 1, 95, 96, 103, 127 and beyond the implemented range. This tells the open lower bound, the open upper bound, the read-only word and range aliasing apart. A second reset with the unlock value as the reset key shows that the lock state at reset comes from the input and not from a constant. Back-to-back discarded writes followed by an idle cycle show that the violation signal is a per-write pulse and not a sticky flag.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] UNLOCK_MAGIC = 32'h1688_A8A8;

    typedef logic [WORD_W-1:0] word_t;

    // Classification of the request present in a cycle
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_READ,
        ACT_COMMIT,
        ACT_DROP_LOCKED,
        ACT_DROP_RO,
        ACT_DROP_RANGE
    } act_e;

    // Registered response state
    typedef struct packed {
        logic  rvalid;
        word_t rdata;
        logic  viol;
    } rsp_t;

endpackage

// File: rtl/sysctl_guard.sv
module sysctl_guard
    import sysctl_pkg::*;
#(
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned NUM_REGS = 128,
    parameter int unsigned KEY_IDX  = 0,
    parameter int unsigned SEG_IDX  = 96,
    parameter int unsigned REV_IDX  = 103
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_idx,
    input  word_t            key_word,
    output act_e             act,
    output logic             in_range
);

    localparam logic [IDX_W:0]   LIMIT_I = (IDX_W+1)'(NUM_REGS);
    localparam logic [IDX_W-1:0] KEY_I   = IDX_W'(KEY_IDX);
    localparam logic [IDX_W-1:0] SEG_I   = IDX_W'(SEG_IDX);
    localparam logic [IDX_W-1:0] REV_I   = IDX_W'(REV_IDX);

    logic unlocked;
    logic guarded;

    always_comb begin
        unlocked = (key_word == UNLOCK_MAGIC);
        in_range = ({1'b0, req_idx} < LIMIT_I);
        guarded  = (req_idx > KEY_I) && (req_idx < SEG_I);
        act      = ACT_IDLE;
        if (req_valid) begin
            if (!req_write) begin
                act = ACT_READ;
            end else if (!in_range) begin
                act = ACT_DROP_RANGE;
            end else if (req_idx == REV_I) begin
                act = ACT_DROP_RO;
            end else if (guarded && !unlocked) begin
                act = ACT_DROP_LOCKED;
            end else begin
                act = ACT_COMMIT;
            end
        end
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_REGS   = 128,
    parameter int unsigned SEL_W      = 7,
    parameter int unsigned KEY_IDX    = 0,
    parameter int unsigned REV_IDX    = 103,
    parameter int unsigned STRAP1_IDX = 28,
    parameter int unsigned STRAP2_IDX = 52,
    parameter int unsigned DEVID_IDX  = 105,
    parameter logic [31:0] DEV_ID_RST = 32'h0000_0A57
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  word_t                      cfg_silicon_rev,
    input  word_t                      cfg_strap_a,
    input  word_t                      cfg_strap_b,
    input  word_t                      cfg_reset_key,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  word_t                      wr_data,
    output logic [NUM_REGS-1:0][31:0]  regs_q
);

    logic [NUM_REGS-1:0][31:0] regs_d;
    logic [NUM_REGS-1:0][31:0] rst_val;

    // Per-word reset source: inputs for key, revision, straps; constants otherwise
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_rst
        if (i == KEY_IDX) begin : g_key
            assign rst_val[i] = cfg_reset_key;
        end else if (i == REV_IDX) begin : g_rev
            assign rst_val[i] = cfg_silicon_rev;
        end else if (i == STRAP1_IDX) begin : g_s1
            assign rst_val[i] = cfg_strap_a;
        end else if (i == STRAP2_IDX) begin : g_s2
            assign rst_val[i] = cfg_strap_b;
        end else if (i == DEVID_IDX) begin : g_dev
            assign rst_val[i] = DEV_ID_RST;
        end else begin : g_zero
            assign rst_val[i] = '0;
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= rst_val;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/sysctl_rdport.sv
module sysctl_rdport
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_REGS = 128,
    parameter int unsigned SEL_W    = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  act_e                      act,
    input  logic                      in_range,
    input  logic [SEL_W-1:0]          sel,
    input  logic [NUM_REGS-1:0][31:0] regs,
    output rsp_t                      rsp_q
);

    rsp_t rsp_d;

    always_comb begin
        rsp_d        = '0;
        rsp_d.rvalid = (act == ACT_READ);
        rsp_d.viol   = (act == ACT_DROP_LOCKED);
        if ((act == ACT_READ) && in_range) begin
            rsp_d.rdata = regs[sel];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg
    import sysctl_pkg::*;
#(
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned NUM_REGS   = 128,
    parameter int unsigned KEY_IDX    = 0,
    parameter int unsigned SEG_IDX    = 96,
    parameter int unsigned REV_IDX    = 103,
    parameter int unsigned STRAP1_IDX = 28,
    parameter int unsigned STRAP2_IDX = 52,
    parameter int unsigned DEVID_IDX  = 105,
    parameter logic [31:0] DEV_ID_RST = 32'h0000_0A57
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cfg_silicon_rev,
    input  logic [31:0]      cfg_strap_a,
    input  logic [31:0]      cfg_strap_b,
    input  logic [31:0]      cfg_reset_key,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [31:0]      req_wdata,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    output logic             lock_violation
);

    localparam int unsigned SEL_W = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0][31:0] regs_q;
    word_t                     key_word;
    act_e                      act;
    logic                      in_range;
    logic [SEL_W-1:0]          sel;
    rsp_t                      rsp_q;

    assign key_word = regs_q[KEY_IDX];
    assign sel      = req_idx[SEL_W-1:0];

    sysctl_guard #(
        .IDX_W    (IDX_W),
        .NUM_REGS (NUM_REGS),
        .KEY_IDX  (KEY_IDX),
        .SEG_IDX  (SEG_IDX),
        .REV_IDX  (REV_IDX)
    ) i_guard (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_idx   (req_idx),
        .key_word  (key_word),
        .act       (act),
        .in_range  (in_range)
    );

    sysctl_regfile #(
        .NUM_REGS   (NUM_REGS),
        .SEL_W      (SEL_W),
        .KEY_IDX    (KEY_IDX),
        .REV_IDX    (REV_IDX),
        .STRAP1_IDX (STRAP1_IDX),
        .STRAP2_IDX (STRAP2_IDX),
        .DEVID_IDX  (DEVID_IDX),
        .DEV_ID_RST (DEV_ID_RST)
    ) i_regfile (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_silicon_rev (cfg_silicon_rev),
        .cfg_strap_a     (cfg_strap_a),
        .cfg_strap_b     (cfg_strap_b),
        .cfg_reset_key   (cfg_reset_key),
        .wr_en           (act == ACT_COMMIT),
        .wr_sel          (sel),
        .wr_data         (req_wdata),
        .regs_q          (regs_q)
    );

    sysctl_rdport #(
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) i_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .in_range (in_range),
        .sel      (sel),
        .regs     (regs_q),
        .rsp_q    (rsp_q)
    );

    assign rsp_valid      = rsp_q.rvalid;
    assign rsp_rdata      = rsp_q.rdata;
    assign lock_violation = rsp_q.viol;

endmodule

// File: rtl/sysctl_keyreg_chk.sv
module sysctl_keyreg_chk
    import sysctl_pkg::*;
#(
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned NUM_REGS = 128,
    parameter int unsigned SEG_IDX  = 96,
    parameter int unsigned REV_IDX  = 103
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_write,
    input logic [IDX_W-1:0]          req_idx,
    input logic [31:0]               req_wdata,
    input logic [31:0]               key_word,
    input logic [NUM_REGS-1:0][31:0] regs,
    input logic                      rsp_valid,
    input logic                      lock_violation
);

    localparam int unsigned      SEL_W   = $clog2(NUM_REGS);
    localparam logic [IDX_W:0]   LIMIT_I = (IDX_W+1)'(NUM_REGS);
    localparam logic [IDX_W-1:0] SEG_I   = IDX_W'(SEG_IDX);
    localparam logic [IDX_W-1:0] REV_I   = IDX_W'(REV_IDX);

    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= rst_n;

    logic wr_any, wr_blocked, wr_key, wr_rev, wr_far, rd_any;
    assign wr_any     = req_valid && req_write;
    assign rd_any     = req_valid && !req_write;
    assign wr_key     = wr_any && (req_idx == '0);
    assign wr_rev     = wr_any && (req_idx == REV_I);
    assign wr_far     = wr_any && ({1'b0, req_idx} >= LIMIT_I);
    assign wr_blocked = wr_any && (req_idx != '0) && (req_idx < SEG_I)
                        && (req_idx != REV_I) && (key_word != UNLOCK_MAGIC);

    a_r4_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        lock_violation |-> $past(wr_blocked));

    a_r4_pulse_fires: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        wr_blocked |=> lock_violation);

    a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        wr_blocked |=> $stable(regs));

    a_r5_key_takes: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        wr_key |=> (key_word == $past(req_wdata)));

    a_r7_rev_fixed: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        wr_rev |=> ($stable(regs) && !lock_violation));

    a_r8_read_answers: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        rd_any |=> rsp_valid);

    a_r8_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !rd_any |=> !rsp_valid);

    a_r9_far_quiet: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        wr_far |=> ($stable(regs) && !lock_violation));

    logic [SEL_W-1:0] unused_sel;
    assign unused_sel = '0;

endmodule

bind sysctl_keyreg sysctl_keyreg_chk #(
    .IDX_W    (IDX_W),
    .NUM_REGS (NUM_REGS),
    .SEG_IDX  (SEG_IDX),
    .REV_IDX  (REV_IDX)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_idx        (req_idx),
    .req_wdata      (req_wdata),
    .key_word       (key_word),
    .regs           (regs_q),
    .rsp_valid      (rsp_valid),
    .lock_violation (lock_violation)
);

// File: tb/test_sysctl_keyreg.sv
`timescale 1ns/1ps
module test_sysctl_keyreg;

    localparam logic [31:0] MAGIC   = 32'h1688_A8A8;
    localparam int          NREGS   = 128;
    localparam int          SEG     = 96;
    localparam int          REV     = 103;
    localparam int          STRAP_A = 28;
    localparam int          STRAP_B = 52;
    localparam int          DEVID   = 105;
    localparam logic [31:0] REV_V   = 32'h0500_0303;
    localparam logic [31:0] SA_V    = 32'hF100_C2E6;
    localparam logic [31:0] SB_V    = 32'h0000_00A0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_reset_key = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_idx = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        lock_violation;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model [NREGS];

    always #4 clk = ~clk;

    sysctl_keyreg i_sysctl_keyreg (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_silicon_rev (REV_V),
        .cfg_strap_a     (SA_V),
        .cfg_strap_b     (SB_V),
        .cfg_reset_key   (cfg_reset_key),
        .req_valid       (req_valid),
        .req_write       (req_write),
        .req_idx         (req_idx),
        .req_wdata       (req_wdata),
        .rsp_valid       (rsp_valid),
        .rsp_rdata       (rsp_rdata),
        .lock_violation  (lock_violation)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [31:0] key);
        cfg_reset_key = key;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NREGS; i++) model[i] = '0;
        model[0]       = key;
        model[REV]     = REV_V;
        model[STRAP_A] = SA_V;
        model[STRAP_B] = SB_V;
        model[DEVID]   = 32'h0000_0A57;
        chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        chk("R1 lock_violation after reset", {31'b0, lock_violation}, 32'd0);
    endtask

    task automatic wr(input int idx, input logic [31:0] d, input string req);
        logic ev;
        ev = (idx > 0) && (idx < SEG) && (model[0] != MAGIC);
        req_valid = 1'b1; req_write = 1'b1; req_idx = idx[9:0]; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(req, {31'b0, lock_violation}, {31'b0, ev});
        if (idx < NREGS && idx != REV && !ev) model[idx] = d;
    endtask

    task automatic rd(input int idx, input string req);
        logic [31:0] exp;
        exp = (idx < NREGS) ? model[idx] : 32'd0;
        req_valid = 1'b1; req_write = 1'b0; req_idx = idx[9:0];
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, {31'b0, rsp_valid}, 32'd1);
        chk({req, " data"}, rsp_rdata, exp);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        chk({req, " viol idle"}, {31'b0, lock_violation}, 32'd0);
        chk({req, " valid idle"}, {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_reset_state;
        do_reset(32'd0);
        rd(0, "R1 key");
        rd(REV, "R1 rev");
        rd(STRAP_A, "R1 strap a");
        rd(STRAP_B, "R1 strap b");
        rd(DEVID, "R1 devid");
        rd(5, "R1 plain");
    endtask

    task automatic t_locked;
        wr(5, 32'hDEAD_BEEF, "R4 locked viol idx5");
        rd(5, "R3 locked idx5 kept");
        wr(STRAP_A, 32'h1234_5678, "R4 locked viol strap");
        wr(95, 32'hAAAA_5555, "R4 locked viol idx95 back-to-back");
        idle("R4 single pulse");
        rd(STRAP_A, "R3 strap kept");
        rd(95, "R3 idx95 kept");
    endtask

    task automatic t_unlock;
        wr(0, MAGIC, "R5 key write");
        rd(0, "R5 key readback");
        wr(5, 32'hCAFE_0001, "R2 unlocked idx5");
        wr(95, 32'hCAFE_0095, "R2 unlocked idx95");
        wr(1, 32'hCAFE_0100, "R2 unlocked idx1");
        idle("R4 no pulse unlocked");
        rd(5, "R2 idx5 landed");
        rd(95, "R2 idx95 landed");
        rd(1, "R2 idx1 landed");
    endtask

    task automatic t_relock;
        wr(0, MAGIC ^ 32'h1, "R5 near-magic key");
        wr(5, 32'h0BAD_0BAD, "R5 relocked viol");
        rd(5, "R3 relocked kept");
        rd(0, "R5 key value");
    endtask

    task automatic t_boundary;
        wr(SEG, 32'h0096_0096, "R6 idx96 locked");
        wr(NREGS - 1, 32'h0127_0127, "R6 idx127 locked");
        wr(DEVID, 32'h0105_0105, "R6 devid locked");
        rd(SEG, "R6 idx96");
        rd(NREGS - 1, "R6 idx127");
        rd(DEVID, "R6 devid");
    endtask

    task automatic t_rev_ro;
        wr(REV, 32'hFFFF_FFFF, "R7 rev write locked");
        rd(REV, "R7 rev kept locked");
        wr(0, MAGIC, "R7 unlock");
        wr(REV, 32'h0, "R7 rev write unlocked");
        rd(REV, "R7 rev kept unlocked");
    endtask

    task automatic t_range;
        wr(200, 32'h7777_7777, "R9 far write");
        rd(200 - NREGS, "R9 no alias");
        rd(200, "R9 far read");
        rd(1023, "R9 top read");
    endtask

    task automatic t_reset_unlocked;
        do_reset(MAGIC);
        rd(0, "R10 key");
        wr(7, 32'h5151_5151, "R10 guarded write no viol");
        wr(STRAP_B, 32'h2222_3333, "R10 strap write");
        rd(7, "R10 idx7 landed");
        rd(STRAP_B, "R10 strap landed");
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_locked();
        t_unlock();
        t_relock();
        t_boundary();
        t_rev_ro();
        t_range();
        t_reset_unlocked();
        idle("R8 tail");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule